// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a fixed-length card reply on the reader side of a proximity link. Its input is a one-bit signal that an analog front end has already thresholded with hysteresis. During a `1` bit the card's load-modulation subcarrier makes this signal toggle many times, and during a `0` bit it stays nearly quiet. The reply has no start marker, no stop marker and no length field. So the caller states how many bits it expects, and timing is anchored to the moment the reader's own transmitter finishes its frame.

On a start strobe the receiver clears its result and latches the requested bit count, clamped to the word width. It then waits a fixed number of ticks and splits the time after that into back-to-back windows of equal length. In each window it counts the level changes of the synchronised input, and a count inside an open band becomes a `1`. The bits are packed least significant first. A one-cycle valid pulse follows the last window. A card that answers with all zeros looks the same as no card at all, so the caller has to tell those cases apart by protocol means.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset `data_o`, `nbits_o` and `valid_o` are all zero.
- R2: The cycle after `start_i` is sampled high, `data_o` and `nbits_o` read zero and `valid_o` is low. A start during reception abandons that reception and begins a new one.
- R3: The requested count `nbits_i` is clamped to 16. A request above 16 receives exactly 16 bits and reports `nbits_o` = 16.
- R4: Reception begins 490 ticks after the start. Level changes on `rx_i` during this delay do not affect the result.
- R5: Bit windows are 150 ticks long and follow one another with no gap. Every change of the synchronised input level inside a window adds one to that window's edge count.
- R6: A window decodes as 1 when its edge count is greater than 20 and less than 60. Any other count, including 20 and 60 themselves, decodes as 0.
- R7: Window k (counting from 0) sets bit k of `data_o`. Bits at and above `nbits_o` are zero.
- R8: `valid_o` is high for exactly one cycle. It appears in the cycle after the tick that ends the last window. At that point `nbits_o` equals the clamped request, and `nbits_o` grows by one per completed window.
- R9: Time advances only on cycles with `tick_i` high. With ticks every other clock, every window stretches to 300 clocks and the decoded result is unchanged.
- R10: A request of zero bits gives `valid_o` in the cycle after the 490th tick, with `data_o` = 0 and `nbits_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Thresholded subcarrier input, asynchronous |
| tick_i | input | 1 | Time-base enable; one tick per cycle where high |
| start_i | input | 1 | Strobe marking the end of the reader frame |
| nbits_i | input | 5 | Number of reply bits expected |
| data_o | output | 16 | Received word, first bit in bit 0 |
| nbits_o | output | 5 | Number of bits received so far |
| valid_o | output | 1 | One-cycle pulse when the reply is complete |

## Verification
The assertions assume that `tick_i` is the only thing that advances time. They also assume that `start_i` is a clean one-cycle strobe between frames, and that `rx_i` moves no faster than the synchroniser can follow. The stimulus keeps to this. It raises `start_i` for a single cycle and generates ticks from a free-running divider. It changes `rx_i` only on the falling clock edge that follows a tick, at most once every two ticks. It places all toggles well inside a window, so that the two-flop delay never pushes an edge across a window boundary.

// File: rtl/sc_edge_rx_pkg.sv
package sc_edge_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_WIN  = 2'd2
  } phase_e;
endpackage

// File: rtl/sc_edge_rx_sync.sv
module sc_edge_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ prev_q;
endmodule

// File: rtl/sc_edge_rx_timer.sv
module sc_edge_rx_timer
  import sc_edge_rx_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 490,
  parameter int unsigned WIN_TICKS  = 150,
  parameter int unsigned CNT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nreq_i,
  output logic             in_win_o,
  output logic             win_end_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             finish_o
);
  localparam int unsigned MAXT = (WAIT_TICKS > WIN_TICKS) ? WAIT_TICKS : WIN_TICKS;
  localparam int unsigned TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_TICKS - 1);
  localparam logic [TW-1:0] WIN_LAST  = TW'(WIN_TICKS - 1);

  phase_e           ph_q;
  logic [TW-1:0]    tcnt_q;
  logic [CNT_W-1:0] idx_q, nreq_q;
  logic             wait_end, last_win;

  assign wait_end  = (ph_q == PH_WAIT) && tick_i && (tcnt_q == WAIT_LAST);
  assign win_end_o = (ph_q == PH_WIN) && tick_i && (tcnt_q == WIN_LAST) && !start_i;
  assign last_win  = (idx_q == nreq_q - 1'b1);
  assign in_win_o  = (ph_q == PH_WIN);
  assign idx_o     = idx_q;
  assign finish_o  = !start_i &&
                     ((wait_end && (nreq_q == '0)) || (win_end_o && last_win));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      nreq_q <= '0;
    end else if (start_i) begin
      ph_q   <= PH_WAIT;
      tcnt_q <= '0;
      idx_q  <= '0;
      nreq_q <= nreq_i;
    end else begin
      unique case (ph_q)
        PH_WAIT: if (tick_i) begin
          if (tcnt_q == WAIT_LAST) begin
            tcnt_q <= '0;
            ph_q   <= (nreq_q == '0) ? PH_IDLE : PH_WIN;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        PH_WIN: if (tick_i) begin
          if (tcnt_q == WIN_LAST) begin
            tcnt_q <= '0;
            idx_q  <= idx_q + 1'b1;
            if (last_win) ph_q <= PH_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sc_edge_rx_edgecnt.sv
module sc_edge_rx_edgecnt #(
  parameter int unsigned EDGE_W  = 8,
  parameter int unsigned EDGE_LO = 20,
  parameter int unsigned EDGE_HI = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic edge_i,
  output logic bit_o
);
  localparam logic [EDGE_W-1:0] LO_V = EDGE_W'(EDGE_LO);
  localparam logic [EDGE_W-1:0] HI_V = EDGE_W'(EDGE_HI);

  logic [EDGE_W-1:0] cnt_q, eff;
  logic [EDGE_W:0]   sum;

  // count including this cycle's edge, so the closing cycle is not lost
  assign sum   = {1'b0, cnt_q} + {{EDGE_W{1'b0}}, (en_i & edge_i)};
  assign eff   = sum[EDGE_W] ? {EDGE_W{1'b1}} : sum[EDGE_W-1:0];
  assign bit_o = (eff > LO_V) && (eff < HI_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= eff;
  end
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx
  import sc_edge_rx_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 490,
  parameter int unsigned WIN_TICKS  = 150,
  parameter int unsigned EDGE_LO    = 20,
  parameter int unsigned EDGE_HI    = 60,
  parameter int unsigned EDGE_W     = 8,
  parameter int unsigned MAX_BITS   = 16,
  parameter int unsigned REQ_W      = 5,
  parameter int unsigned CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [REQ_W-1:0]    nbits_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [CNT_W-1:0]    nbits_o,
  output logic                valid_o
);
  localparam int unsigned DI_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic             edge_s, in_win, win_end, finish, bit_val;
  logic [CNT_W-1:0] idx, req_clamped;
  logic [MAX_BITS-1:0] data_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                valid_q;

  assign req_clamped = (int'(nbits_i) > int'(MAX_BITS)) ? CNT_W'(MAX_BITS)
                                                        : CNT_W'(nbits_i);

  sc_edge_rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .edge_o (edge_s)
  );

  sc_edge_rx_timer #(
    .WAIT_TICKS (WAIT_TICKS),
    .WIN_TICKS  (WIN_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .nreq_i    (req_clamped),
    .in_win_o  (in_win),
    .win_end_o (win_end),
    .idx_o     (idx),
    .finish_o  (finish)
  );

  sc_edge_rx_edgecnt #(
    .EDGE_W  (EDGE_W),
    .EDGE_LO (EDGE_LO),
    .EDGE_HI (EDGE_HI)
  ) u_edgecnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_win),
    .clr_i  (win_end | start_i),
    .edge_i (edge_s),
    .bit_o  (bit_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (win_end) begin
        data_q[idx[DI_W-1:0]] <= bit_val;
        cnt_q                 <= cnt_q + 1'b1;
      end
    end
  end

  assign data_o  = data_q;
  assign nbits_o = cnt_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sc_edge_rx_chk.sv
module sc_edge_rx_chk #(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned REQ_W    = 5,
  parameter int unsigned CNT_W    = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rx_i,
  input logic                tick_i,
  input logic                start_i,
  input logic [REQ_W-1:0]    nbits_i,
  input logic [MAX_BITS-1:0] data_o,
  input logic [CNT_W-1:0]    nbits_o,
  input logic                valid_o
);
  // R8: single-cycle completion pulse
  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8: count only ever steps by one outside a restart
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(start_i) && (nbits_o != $past(nbits_o))) |-> (nbits_o == $past(nbits_o) + 1'b1));

  // R3: count never exceeds the word width
  a_r3_count_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(nbits_o) <= int'(MAX_BITS));

  // R2: start clears the result
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (data_o == '0) && (nbits_o == '0) && !valid_o);

  // R7: no bits set above the received count
  a_r7_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nbits_o) == '0));

  // R9: without a tick nothing in the result moves
  a_r9_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> ($stable(nbits_o) && $stable(data_o)));

  logic unused_ok;
  assign unused_ok = rx_i ^ (^nbits_i);
endmodule

bind sc_edge_rx sc_edge_rx_chk #(
  .MAX_BITS (MAX_BITS),
  .REQ_W    (REQ_W),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/sc_edge_rx_tb.sv
module sc_edge_rx_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  nbits_i = '0;
  logic [15:0] data_o;
  logic [4:0]  nbits_o;
  logic        valid_o;

  int total = 0;
  int bad   = 0;
  int tdiv  = 1;
  int cyc   = 0;
  bit done  = 0;

  typedef struct { logic [15:0] d; logic [4:0] n; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  sc_edge_rx u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .tick_i  (tick_i),
    .start_i (start_i),
    .nbits_i (nbits_i),
    .data_o  (data_o),
    .nbits_o (nbits_o),
    .valid_o (valid_o)
  );

  always @(negedge clk_i) begin
    cyc    <= cyc + 1;
    tick_i <= ((cyc % tdiv) == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pop expected result on every valid pulse (R7, R8)
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R7 data word", 32'(data_o), 32'(e.d));
        check("R8 bit count", 32'(nbits_o), 32'(e.n));
      end
    end
  end

  task automatic next_tick();
    do @(posedge clk_i); while (!tick_i);
  endtask

  task automatic run_frame(input int nreq, input int e[16], input bit noise, input string tag);
    int n;
    exp_t x;
    n = (nreq > 16) ? 16 : nreq;
    x.d = '0;
    x.n = 5'(n);
    for (int i = 0; i < n; i++) x.d[i] = (e[i] > 20) && (e[i] < 60);
    exp_q.push_back(x);
    @(negedge clk_i);
    nbits_i = 5'(nreq);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check({"R2 clear data ", tag}, 32'(data_o), 32'd0);
    check({"R2 clear count ", tag}, 32'(nbits_o), 32'd0);
    for (int t = 1; t <= 490; t++) begin
      next_tick();
      if (noise && t >= 10 && t <= 400 && (t % 3) == 0) begin
        @(negedge clk_i);
        rx_i = ~rx_i;
      end
    end
    for (int w = 0; w < n; w++) begin
      for (int t = 1; t <= 150; t++) begin
        next_tick();
        if (t >= 5 && t < 5 + 2 * e[w] && ((t - 5) % 2) == 0) begin
          @(negedge clk_i);
          rx_i = ~rx_i;
        end
      end
    end
    @(negedge clk_i);
    check({"R8 valid after last window ", tag}, 32'(valid_o), 32'd1);
    @(negedge clk_i);
    check({"R8 valid one cycle ", tag}, 32'(valid_o), 32'd0);
    repeat (5) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int e[16];
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset data", 32'(data_o), 32'd0);
    check("R1 reset count", 32'(nbits_o), 32'd0);
    check("R1 reset valid", 32'(valid_o), 32'd0);

    // R5 R6 R7: plain pattern, LSB first
    e = '{42,0,42,42,0,0,42,0, 0,0,0,0,0,0,0,0};
    run_frame(8, e, 0, "basic");
    // R6: band edges
    e = '{20,21,59,60,1,19,61,70, 0,0,0,0,0,0,0,0};
    run_frame(8, e, 0, "band");
    // R3: clamp a request of 20
    e = '{42,0,42,0,42,42,0,0, 42,0,0,42,42,42,0,42};
    run_frame(20, e, 0, "clamp");
    // R4: heavy toggling during the delay is ignored
    e = '{0,42,0,42, 0,0,0,0, 0,0,0,0,0,0,0,0};
    run_frame(4, e, 1, "wait_noise");
    // zero reply looks like silence
    e = '{default: 0};
    run_frame(16, e, 0, "all_zero");
    // R10: nothing requested
    run_frame(0, e, 0, "zero_req");
    // R9: ticks every second clock
    tdiv = 2;
    e = '{42,42,0,30, 0,0,0,0, 0,0,0,0,0,0,0,0};
    run_frame(4, e, 0, "slow_tick");
    tdiv = 1;
    repeat (4) @(negedge clk_i);
    check("R8 all replies seen", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule